// File: doc/BRIEF.md
# Up/Down Timer with Capture-Compare Clear

This block is a 16-bit counter that steps up or down once per prescaler period. An 8-bit prescaler counts down from a programmable reload value, and the counter takes one step each time the prescaler reaches zero. A byte-wide register bus sets the controls and reads back the counter, a load register, a compare register and two capture registers. Counting only runs while a local enable bit and a chip-level global enable input are both high. Three trigger inputs act even while counting is halted: one loads the counter, and two capture it.

An enable bit can make either capture also clear the counter and restart the prescaler. A second enable bit does the same on a compare match, which gives a periodic count. Software can clear the counter through a write-only strobe bit. The counting direction comes from a software bit unless an external override input is asserted. A latched status bit tells software whether the counter wrapped since the previous capture into capture register 0. A single interrupt line pulses on every capture, compare event and wrap.

The bus is a plain register interface and has no back-pressure. A write takes effect at the clock edge in which `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low.

Top module: `udt_timer`

## Requirements
- R1: After reset, every readable address reads 00h while `dir_force_en` and `glb_en` are low. The readable addresses are 0 control, 1 prescaler reload, 2/3 load low/high, 4/5 compare low/high, 6/7 capture 0 low/high, 8/9 capture 1 low/high and 10/11 counter low/high.
- R2: The counter and the prescaler advance only in cycles where control bit 7 (enable) and `glb_en` are both 1. Dropping either one holds the count, and restoring it resumes from the held value without a reload. Control bit 0 reads 1 exactly when both are 1. Writes to control bits 2..0 are ignored.
- R3: With prescaler reload P (address 1), the counter steps once every P+1 enabled cycles. A load, a capture-clear or a compare-clear restarts the prescaler from P.
- R4: Control bit 3 selects up (1) or down (0). When `dir_force_en` is 1, `dir_force_up` selects the direction instead. Control bit 2 reads the direction in use (1 = up).
- R5: A step up from FFFFh gives 0000h, and a step down from 0000h gives FFFFh.
- R6: A `trig_load` pulse copies the load register into the counter and restarts the prescaler, whatever the enables are. It has priority over every clear and every step.
- R7: A `trig_cap0` or `trig_cap1` pulse copies the counter value of that cycle into capture register 0 or 1, whatever the enables are.
- R8: When control bit 6 is 1, a pulse on either capture trigger also clears the counter and restarts the prescaler.
- R9: A compare event is a step whose result equals the compare register. When control bit 5 is 1, that step yields 0000h and restarts the prescaler. So with P=0, counting up from 0 toward compare value C, the counter reads N mod C after N enabled cycles.
- R10: Writing control with bit 4 set clears the counter and raises no interrupt. Bit 4 always reads 0.
- R11: At each `trig_cap0` pulse, control bit 1 latches whether a wrap happened since the previous capture-0 event, including a wrap in the same cycle. A read of the control register clears it, and `trig_cap1` leaves it unchanged.
- R12: `irq` goes high for exactly one cycle, in the cycle after each capture, compare event or wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Chip-level count enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| trig_load | input | 1 | Load counter from load register |
| trig_cap0 | input | 1 | Capture into capture register 0 |
| trig_cap1 | input | 1 | Capture into capture register 1 |
| dir_force_en | input | 1 | External direction override enable |
| dir_force_up | input | 1 | Forced direction, 1 = up |
| irq | output | 1 | One-cycle event pulse |

## Verification
The checker enforces four rules on every cycle:
- a capture always takes the counter value of the trigger cycle;
- a halted counter never moves without a load, capture or clear;
- a software clear always zeroes the count, and its bit always reads 0;
- the wrap status bit only rises right after a capture-0 pulse.

Prescaler period arithmetic, compare-period counts, direction override and the read-to-clear timing of the wrap flag are shown only by the bench's sweeps. The bench compares these against values it computes itself.

// File: rtl/udt_pkg.sv
`timescale 1ns/1ps
package udt_pkg;
  typedef enum logic [3:0] {
    A_CTL  = 4'd0,
    A_PSC  = 4'd1,
    A_LDL  = 4'd2,
    A_LDH  = 4'd3,
    A_CMPL = 4'd4,
    A_CMPH = 4'd5,
    A_C0L  = 4'd6,
    A_C0H  = 4'd7,
    A_C1L  = 4'd8,
    A_C1H  = 4'd9,
    A_CNL  = 4'd10,
    A_CNH  = 4'd11
  } reg_addr_e;

  localparam int CB_EN   = 7;
  localparam int CB_CCP  = 6;
  localparam int CB_CCMP = 5;
  localparam int CB_SWC  = 4;
  localparam int CB_UDC  = 3;
endpackage

// File: rtl/udt_regs.sv
`timescale 1ns/1ps
module udt_regs
  import udt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cap0,
  input  logic [CNT_W-1:0] cap1,
  input  logic             ovf,
  input  logic             dir_up,
  input  logic             run,
  output logic             ctl_en,
  output logic             ctl_ccp,
  output logic             ctl_ccmp,
  output logic             ctl_udc,
  output logic             sw_clr,
  output logic             ctl_rd,
  output logic [PSC_W-1:0] psc_rld,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cmp_val
);
  localparam int HI_W = CNT_W - 8;

  logic      wr_s, rd_s;
  reg_addr_e addr;

  assign addr   = reg_addr_e'(bus_addr);
  assign wr_s   = bus_sel & bus_wr;
  assign rd_s   = bus_sel & ~bus_wr;
  assign sw_clr = wr_s && (addr == A_CTL) && bus_wdata[CB_SWC];
  assign ctl_rd = rd_s && (addr == A_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_ccp  <= 1'b0;
      ctl_ccmp <= 1'b0;
      ctl_udc  <= 1'b0;
      psc_rld  <= '0;
      load_val <= '0;
      cmp_val  <= '0;
    end else if (wr_s) begin
      case (addr)
        A_CTL: begin
          ctl_en   <= bus_wdata[CB_EN];
          ctl_ccp  <= bus_wdata[CB_CCP];
          ctl_ccmp <= bus_wdata[CB_CCMP];
          ctl_udc  <= bus_wdata[CB_UDC];
        end
        A_PSC:  psc_rld           <= bus_wdata[PSC_W-1:0];
        A_LDL:  load_val[7:0]     <= bus_wdata;
        A_LDH:  load_val[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
        A_CMPL: cmp_val[7:0]      <= bus_wdata;
        A_CMPH: cmp_val[CNT_W-1:8]  <= bus_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_s) begin
      case (addr)
        A_CTL:  bus_rdata = {ctl_en, ctl_ccp, ctl_ccmp, 1'b0, ctl_udc, dir_up, ovf, run};
        A_PSC:  bus_rdata = 8'(psc_rld);
        A_LDL:  bus_rdata = load_val[7:0];
        A_LDH:  bus_rdata = 8'(load_val >> 8);
        A_CMPL: bus_rdata = cmp_val[7:0];
        A_CMPH: bus_rdata = 8'(cmp_val >> 8);
        A_C0L:  bus_rdata = cap0[7:0];
        A_C0H:  bus_rdata = 8'(cap0 >> 8);
        A_C1L:  bus_rdata = cap1[7:0];
        A_C1H:  bus_rdata = 8'(cap1 >> 8);
        A_CNL:  bus_rdata = cnt[7:0];
        A_CNH:  bus_rdata = 8'(cnt >> 8);
        default: bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/udt_prescaler.sv
`timescale 1ns/1ps
module udt_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] reload,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt;

  assign tick = run && (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= reload;
    else if (run)     pcnt <= (pcnt == '0) ? reload : pcnt - 1'b1;
  end
endmodule

// File: rtl/udt_core.sv
`timescale 1ns/1ps
module udt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dir_up,
  input  logic             trig_load,
  input  logic             trig_cap0,
  input  logic             trig_cap1,
  input  logic             ccp,
  input  logic             ccmp,
  input  logic             sw_clr,
  input  logic             ctl_rd,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap0,
  output logic [CNT_W-1:0] cap1,
  output logic             ovf,
  output logic             irq,
  output logic             psc_restart
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             cap_clr, step_go, cmp_hit, wrap_now, wrap_pend;
  logic [CNT_W-1:0] step_val, cnt_nxt;

  assign cap_clr     = (trig_cap0 | trig_cap1) & ccp;
  assign step_val    = dir_up ? cnt + 1'b1 : cnt - 1'b1;
  assign step_go     = tick & ~trig_load & ~cap_clr & ~sw_clr;
  assign cmp_hit     = step_go && (step_val == cmp_val);
  assign wrap_now    = step_go && (dir_up ? (cnt == CNT_MAX) : (cnt == '0));
  assign psc_restart = trig_load | cap_clr | (cmp_hit & ccmp);

  always_comb begin
    if (trig_load)              cnt_nxt = load_val;
    else if (cap_clr || sw_clr) cnt_nxt = '0;
    else if (step_go)           cnt_nxt = (cmp_hit && ccmp) ? '0 : step_val;
    else                        cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cap0      <= '0;
      cap1      <= '0;
      ovf       <= 1'b0;
      wrap_pend <= 1'b0;
      irq       <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      irq <= trig_cap0 | trig_cap1 | cmp_hit | wrap_now;
      if (trig_cap0) cap0 <= cnt;
      if (trig_cap1) cap1 <= cnt;
      if (trig_cap0) begin
        ovf       <= wrap_pend | wrap_now;
        wrap_pend <= 1'b0;
      end else begin
        if (ctl_rd)   ovf       <= 1'b0;
        if (wrap_now) wrap_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/udt_timer.sv
`timescale 1ns/1ps
module udt_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       glb_en,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       trig_load,
  input  logic       trig_cap0,
  input  logic       trig_cap1,
  input  logic       dir_force_en,
  input  logic       dir_force_up,
  output logic       irq
);
  logic             ctl_en, ctl_ccp, ctl_ccmp, ctl_udc, sw_clr, ctl_rd;
  logic             run, dir_up, tick, psc_restart, ovf_q;
  logic [PSC_W-1:0] psc_rld;
  logic [CNT_W-1:0] load_val, cmp_val, cnt_q, cap0_q, cap1_q;

  assign run    = ctl_en & glb_en;
  assign dir_up = dir_force_en ? dir_force_up : ctl_udc;

  udt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt_q), .cap0(cap0_q), .cap1(cap1_q), .ovf(ovf_q),
    .dir_up(dir_up), .run(run),
    .ctl_en(ctl_en), .ctl_ccp(ctl_ccp), .ctl_ccmp(ctl_ccmp), .ctl_udc(ctl_udc),
    .sw_clr(sw_clr), .ctl_rd(ctl_rd), .psc_rld(psc_rld),
    .load_val(load_val), .cmp_val(cmp_val)
  );

  udt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(psc_restart),
    .reload(psc_rld), .tick(tick)
  );

  udt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dir_up(dir_up),
    .trig_load(trig_load), .trig_cap0(trig_cap0), .trig_cap1(trig_cap1),
    .ccp(ctl_ccp), .ccmp(ctl_ccmp), .sw_clr(sw_clr), .ctl_rd(ctl_rd),
    .load_val(load_val), .cmp_val(cmp_val),
    .cnt(cnt_q), .cap0(cap0_q), .cap1(cap1_q), .ovf(ovf_q),
    .irq(irq), .psc_restart(psc_restart)
  );
endmodule

// File: rtl/udt_chk.sv
`timescale 1ns/1ps
module udt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             ctl_en,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic             trig_load,
  input logic             trig_cap0,
  input logic             trig_cap1,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap0_q,
  input logic             ovf_q
);
  logic swc_wr, ctl_read;
  assign swc_wr   = bus_sel && bus_wr && (bus_addr == 4'd0) && bus_wdata[4];
  assign ctl_read = bus_sel && !bus_wr && (bus_addr == 4'd0);

  // R7
  cap0_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_cap0 |=> (cap0_q == $past(cnt_q)));

  // R2
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctl_en && glb_en) && !trig_load && !trig_cap0 && !trig_cap1 && !swc_wr)
      |=> $stable(cnt_q));

  // R10
  swclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swc_wr && !trig_load) |=> (cnt_q == '0));

  // R10
  swclr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_read |-> (bus_rdata[4] == 1'b0));

  // R11
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(trig_cap0));
endmodule

bind udt_timer udt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ctl_en(ctl_en),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .trig_load(trig_load), .trig_cap0(trig_cap0), .trig_cap1(trig_cap1),
  .cnt_q(cnt_q), .cap0_q(cap0_q), .ovf_q(ovf_q)
);

// File: tb/udt_timer_tb.sv
`timescale 1ns/1ps
module udt_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glb_en = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       trig_load = 1'b0, trig_cap0 = 1'b0, trig_cap1 = 1'b0;
  logic       dir_force_en = 1'b0, dir_force_up = 1'b0;
  logic       irq;
  int         n_cmp = 0, n_bad = 0, irq_seen = 0;

  always #2.5 clk = ~clk;

  udt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_load(trig_load), .trig_cap0(trig_cap0), .trig_cap1(trig_cap1),
    .dir_force_en(dir_force_en), .dir_force_up(dir_force_up), .irq(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_seen <= irq_seen + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(4'(a + 1), hi);
    v = {hi, lo};
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a, v[7:0]);
    wr(4'(a + 1), v[15:8]);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: trig_load = 1'b1;
      1: trig_cap0 = 1'b1;
      default: trig_cap1 = 1'b1;
    endcase
    @(negedge clk);
    trig_load = 1'b0; trig_cap0 = 1'b0; trig_cap1 = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr16(4'd2, v);
    pulse(0);
  endtask

  task automatic run_for(input int n);
    glb_en = 1'b1;
    repeat (n) @(negedge clk);
    glb_en = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of every address
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), b);
      chk($sformatf("R1 addr %0d", a), b, 0);
    end

    // R2 read-only bits ignore writes
    wr(4'd0, 8'h07);
    rd(4'd0, b); chk("R2 ro bits", b, 8'h00);

    // R3 R4 R6 prescaler/direction sweep
    for (int r = 0; r < 4; r++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 2; k++) begin
          int n, t, e;
          n = (k != 0) ? 9 : 5;
          t = n / (r + 1);
          e = (d != 0) ? 32'h1000 + t : 32'h1000 - t;
          wr(4'd1, 8'(r));
          wr(4'd0, (d != 0) ? 8'h88 : 8'h80);
          load(16'h1000);
          run_for(n);
          rd16(4'd10, v);
          chk($sformatf("R3 p=%0d up=%0d n=%0d", r, d, n), v, e);
        end

    // R6 load while halted
    wr(4'd0, 8'h00);
    load(16'hBEEF);
    rd16(4'd10, v); chk("R6 load", v, 16'hBEEF);

    // R2 gating by both enables, resume without reload
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h88);
    load(16'h0200);
    run_for(3);
    repeat (4) @(negedge clk);
    rd16(4'd10, v); chk("R2 glb stop", v, 16'h0203);
    wr(4'd0, 8'h08);
    run_for(4);
    rd16(4'd10, v); chk("R2 local stop", v, 16'h0203);
    wr(4'd0, 8'h88);
    run_for(2);
    rd16(4'd10, v); chk("R2 resume", v, 16'h0205);
    glb_en = 1'b1;
    rd(4'd0, b); chk("R2 running status", b, 8'h8D);
    glb_en = 1'b0;
    rd(4'd0, b); chk("R2 halted status", b, 8'h8C);

    // R5 R11 R12 up wrap
    load(16'hFFFE);
    irq_seen = 0;
    run_for(3);
    rd16(4'd10, v); chk("R5 up wrap", v, 16'h0001);
    chk("R12 wrap irq", irq_seen, 1);
    rd(4'd0, b); chk("R11 no capture yet", b, 8'h8C);
    pulse(2);
    rd(4'd0, b); chk("R11 cap1 leaves flag", b, 8'h8C);
    pulse(1);
    rd16(4'd6, v); chk("R7 cap0 value", v, 16'h0001);
    rd(4'd0, b); chk("R11 flag set", b, 8'h8E);
    rd(4'd0, b); chk("R11 cleared by read", b, 8'h8C);

    // R5 R11 down wrap
    wr(4'd0, 8'h80);
    load(16'h0001);
    run_for(3);
    rd16(4'd10, v); chk("R5 down wrap", v, 16'hFFFE);
    pulse(1);
    rd(4'd0, b); chk("R11 down flag", b, 8'h82);
    pulse(1);
    rd(4'd0, b); chk("R11 no wrap since", b, 8'h80);

    // R7 capture while halted
    wr(4'd0, 8'h00);
    load(16'h1234);
    pulse(2);
    rd16(4'd8, v); chk("R7 cap1 halted", v, 16'h1234);
    rd16(4'd10, v); chk("R7 counter kept", v, 16'h1234);

    // R8 clear on capture with prescaler restart
    wr(4'd1, 8'h03);
    wr(4'd0, 8'hC8);
    load(16'h0050);
    run_for(2);
    pulse(2);
    rd16(4'd8, v); chk("R8 cap1 value", v, 16'h0050);
    rd16(4'd10, v); chk("R8 cleared", v, 16'h0000);
    run_for(3);
    rd16(4'd10, v); chk("R8 psc restarted", v, 16'h0000);
    run_for(1);
    rd16(4'd10, v); chk("R8 first step", v, 16'h0001);

    // R9 R12 compare period sweep
    wr(4'd1, 8'h00);
    for (int c = 3; c <= 7; c += 2) begin
      wr(4'd0, 8'hA8);
      wr16(4'd4, 16'(c));
      load(16'h0000);
      irq_seen = 0;
      run_for(12);
      repeat (2) @(negedge clk);
      rd16(4'd10, v); chk($sformatf("R9 cmp=%0d value", c), v, 12 % c);
      chk($sformatf("R12 cmp=%0d irq", c), irq_seen, 12 / c);
    end
    wr(4'd0, 8'h88);
    wr16(4'd4, 16'd5);
    load(16'h0000);
    irq_seen = 0;
    run_for(7);
    repeat (2) @(negedge clk);
    rd16(4'd10, v); chk("R9 no clear", v, 7);
    chk("R12 single match", irq_seen, 1);

    // R10 software clear
    wr(4'd0, 8'h08);
    load(16'h00AA);
    irq_seen = 0;
    wr(4'd0, 8'h18);
    repeat (2) @(negedge clk);
    rd16(4'd10, v); chk("R10 cleared", v, 0);
    chk("R10 no irq", irq_seen, 0);
    rd(4'd0, b); chk("R10 bit reads 0", b, 8'h0C);

    // R4 direction override
    dir_force_en = 1'b1; dir_force_up = 1'b1;
    wr(4'd0, 8'h80);
    rd(4'd0, b); chk("R4 forced up status", b, 8'h84);
    load(16'h0100);
    run_for(4);
    rd16(4'd10, v); chk("R4 forced up count", v, 16'h0104);
    dir_force_up = 1'b0;
    wr(4'd0, 8'h88);
    rd(4'd0, b); chk("R4 forced down status", b, 8'h88);
    run_for(2);
    rd16(4'd10, v); chk("R4 forced down count", v, 16'h0102);
    dir_force_en = 1'b0;
    rd(4'd0, b); chk("R4 software status", b, 8'h8C);

    summary();
  end
endmodule